// File: doc/BRIEF.md
# Bus-Master Inbound Window Decoder

This block classifies every 32-bit address that a bus master on the expansion bus drives toward the host and turns it into a target choice plus a translated address. The low window, starting at zero, folds back onto the expansion-bus memory space with the address passed through untouched. The upper half of the 4 GB space reaches host system memory, rebased so that inbound 0x8000_0000 lands on host address zero. Everything between the two windows is a hole and raises an error.

One map serves every requester, whatever its device/function number; the requester identity travels alongside only so the response can be steered back. The result is registered. A request presented in cycle N appears on the outputs after the clock edge that ends cycle N, with target, address, error flag, write flag, write data and requester tag all valid together. For a read that falls in the hole the block returns all-ones read data. A write that falls in the hole never shows a forwarding strobe.

Top module: `bm_inbound_decoder`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first edge after it is released with no request, `out_valid` is 0, `out_target` is 2'b00 (NONE) and `out_addr` is 0.
- R2: A request with address below the PCI window limit (default 0x3F00_0000) gives `out_target` = 2'b01 (PCI) and `out_addr` equal to the inbound address.
- R3: A request with address at or above the system base (default 0x8000_0000) gives `out_target` = 2'b10 (SYS) and `out_addr` = address − 0x8000_0000.
- R4: A request with an address in [0x3F00_0000, 0x7FFF_FFFF] gives `out_target` = 2'b11 (HOLE), `out_err` = 1 and `out_addr` = 0. `out_err` is 0 for every other target.
- R5: Outputs follow the accepted request by exactly one clock. `out_valid` is the registered `in_valid`, and every other output is registered on the same edge.
- R6: The translation ignores `in_devfn`. The same address gives the same target and address for any requester, and `out_devfn` is the registered `in_devfn`.
- R7: A write into the hole produces no forwarding. `out_fwd_wr` is 1 only for a valid write whose target is PCI or SYS.
- R8: A read into the hole returns `out_rdata` = all ones. For every other access `out_rdata` is 0, and `out_wdata` carries the registered write data.
- R9: With `in_valid` low the outputs hold `out_valid` = 0 and `out_target` = NONE on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 32 | Inbound bus address |
| in_write | input | 1 | 1 for write, 0 for read |
| in_wdata | input | 32 | Write data |
| in_devfn | input | 8 | Requester device/function number |
| out_valid | output | 1 | Registered request strobe |
| out_target | output | 2 | 00 NONE, 01 PCI, 10 SYS, 11 HOLE |
| out_addr | output | 32 | Translated address |
| out_err | output | 1 | Unmapped access |
| out_write | output | 1 | Registered write flag |
| out_fwd_wr | output | 1 | Write forwarded to a real target |
| out_wdata | output | 32 | Registered write data |
| out_rdata | output | 32 | Fill data for hole reads |
| out_devfn | output | 8 | Registered requester tag |

## Verification
The assertions assume that the inbound address, write flag and requester tag are known whenever `in_valid` is high. They also assume the default window constants, so the PCI limit lies below the system base. The bench drives fully defined values on every cycle, including idle ones. Its random addresses are drawn across the whole 32-bit space, and they are joined by directed values on each side of both window edges.

// File: rtl/bm_inbound_pkg.sv
package bm_inbound_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_PCI  = 2'b01,
    TGT_SYS  = 2'b10,
    TGT_HOLE = 2'b11
  } tgt_e;

  typedef struct packed {
    tgt_e        target;
    logic [31:0] addr;
  } xlat_t;
endpackage

// File: rtl/bm_window_match.sv
module bm_window_match #(
  parameter int          AW       = 32,
  parameter logic [31:0] PCI_LIM  = 32'h3F00_0000,
  parameter logic [31:0] SYS_BASE = 32'h8000_0000
) (
  input  logic [AW-1:0] addr,
  output logic          hit_pci,
  output logic          hit_sys
);
  localparam logic [AW-1:0] LIM_W  = AW'(PCI_LIM);
  localparam logic [AW-1:0] BASE_W = AW'(SYS_BASE);

  always_comb begin
    hit_pci = (addr < LIM_W);
    hit_sys = (addr >= BASE_W);
  end
endmodule

// File: rtl/bm_addr_xlate.sv
module bm_addr_xlate
  import bm_inbound_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] SYS_BASE = 32'h8000_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          hit_pci,
  input  logic          hit_sys,
  output tgt_e          target,
  output logic [AW-1:0] xaddr
);
  localparam logic [AW-1:0] BASE_W = AW'(SYS_BASE);

  always_comb begin
    if (hit_pci) begin
      target = TGT_PCI;
      xaddr  = addr;
    end else if (hit_sys) begin
      target = TGT_SYS;
      xaddr  = addr - BASE_W;
    end else begin
      target = TGT_HOLE;
      xaddr  = '0;
    end
  end
endmodule

// File: rtl/bm_inbound_decoder.sv
module bm_inbound_decoder
  import bm_inbound_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          TW       = 8,
  parameter logic [31:0] PCI_LIM  = 32'h3F00_0000,
  parameter logic [31:0] SYS_BASE = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  input  logic [TW-1:0] in_devfn,
  output logic          out_valid,
  output logic [1:0]    out_target,
  output logic [AW-1:0] out_addr,
  output logic          out_err,
  output logic          out_write,
  output logic          out_fwd_wr,
  output logic [DW-1:0] out_wdata,
  output logic [DW-1:0] out_rdata,
  output logic [TW-1:0] out_devfn
);
  localparam logic [DW-1:0] FILL = {DW{1'b1}};

  logic          hit_pci, hit_sys;
  tgt_e          tgt_c;
  logic [AW-1:0] xaddr_c;

  bm_window_match #(.AW(AW), .PCI_LIM(PCI_LIM), .SYS_BASE(SYS_BASE)) u_match (
    .addr(in_addr), .hit_pci(hit_pci), .hit_sys(hit_sys)
  );

  bm_addr_xlate #(.AW(AW), .SYS_BASE(SYS_BASE)) u_xlate (
    .addr(in_addr), .hit_pci(hit_pci), .hit_sys(hit_sys),
    .target(tgt_c), .xaddr(xaddr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_target <= TGT_NONE;
      out_addr   <= '0;
      out_err    <= 1'b0;
      out_write  <= 1'b0;
      out_fwd_wr <= 1'b0;
      out_wdata  <= '0;
      out_rdata  <= '0;
      out_devfn  <= '0;
    end else begin
      out_valid <= in_valid;
      out_devfn <= in_devfn;
      out_write <= in_valid & in_write;
      out_wdata <= in_wdata;
      if (in_valid) begin
        out_target <= tgt_c;
        out_addr   <= xaddr_c;
        out_err    <= (tgt_c == TGT_HOLE);
        out_fwd_wr <= in_write & (tgt_c != TGT_HOLE);
        out_rdata  <= (!in_write && tgt_c == TGT_HOLE) ? FILL : '0;
      end else begin
        out_target <= TGT_NONE;
        out_addr   <= '0;
        out_err    <= 1'b0;
        out_fwd_wr <= 1'b0;
        out_rdata  <= '0;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (!out_valid && out_target == 2'b00));
  // R2
  pci_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr < AW'(PCI_LIM)) |=> (out_target == 2'b01 && out_addr == $past(in_addr)));
  // R3
  sys_rebase_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr >= AW'(SYS_BASE)) |=> (out_target == 2'b10 && out_addr == $past(in_addr) - AW'(SYS_BASE)));
  // R4
  hole_err_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_target == 2'b11 && out_valid));
  // R5
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  no_hole_wr_chk: assert property (@(posedge clk) disable iff (rst)
    out_fwd_wr |-> (!out_err && out_valid && out_write));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_target == 2'b00));
endmodule

// File: tb/bm_inbound_decoder_bench.sv
`timescale 1ns/1ps
module bm_inbound_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        in_write = 1'b0;
  logic [31:0] in_wdata = '0;
  logic [7:0]  in_devfn = '0;
  logic        out_valid, out_err, out_write, out_fwd_wr;
  logic [1:0]  out_target;
  logic [31:0] out_addr, out_wdata, out_rdata;
  logic [7:0]  out_devfn;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bm_inbound_decoder u_bm_inbound_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_write(in_write), .in_wdata(in_wdata), .in_devfn(in_devfn),
    .out_valid(out_valid), .out_target(out_target), .out_addr(out_addr),
    .out_err(out_err), .out_write(out_write), .out_fwd_wr(out_fwd_wr),
    .out_wdata(out_wdata), .out_rdata(out_rdata), .out_devfn(out_devfn)
  );

  function automatic logic [1:0] exp_tgt(input logic [31:0] a);
    if (a < 32'h3F00_0000) return 2'b01;
    if (a >= 32'h8000_0000) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    case (exp_tgt(a))
      2'b01:   return a;
      2'b10:   return a - 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d, input logic [7:0] f);
    logic [1:0] t;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_write = w; in_wdata = d; in_devfn = f;
    @(negedge clk);
    in_valid = 1'b0;
    t = exp_tgt(a);
    chk("R5", "valid", {31'b0, out_valid}, 32'd1);
    chk(t == 2'b01 ? "R2" : (t == 2'b10 ? "R3" : "R4"), "target", {30'b0, out_target}, {30'b0, t});
    chk(t == 2'b01 ? "R2" : (t == 2'b10 ? "R3" : "R4"), "addr", out_addr, exp_addr(a));
    chk("R4", "err", {31'b0, out_err}, {31'b0, t == 2'b11});
    chk("R7", "fwd_wr", {31'b0, out_fwd_wr}, {31'b0, w && t != 2'b11});
    chk("R8", "rdata", out_rdata, (!w && t == 2'b11) ? 32'hFFFF_FFFF : 32'h0);
    chk("R8", "wdata", out_wdata, d);
    chk("R6", "devfn", {24'b0, out_devfn}, {24'b0, f});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R1", "target in reset", {30'b0, out_target}, 32'd0);
    chk("R1", "addr in reset", out_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", {31'b0, out_valid}, 32'd0);
    access(32'h0000_0000, 1'b0, 32'h1, 8'h00);
    access(32'h3EFF_FFFF, 1'b1, 32'hA5A5_0001, 8'h08);
    access(32'h3F00_0000, 1'b0, 32'h0, 8'h10);
    access(32'h3F00_0000, 1'b1, 32'h1234_5678, 8'h18);
    access(32'h7FFF_FFFF, 1'b1, 32'hDEAD_BEEF, 8'h20);
    access(32'h8000_0000, 1'b0, 32'h0, 8'h28);
    access(32'hFFFF_FFFF, 1'b1, 32'hCAFE_0000, 8'hF8);
    // R6: the same address from differing requesters
    access(32'h9000_1234, 1'b0, 32'h0, 8'h00);
    access(32'h9000_1234, 1'b0, 32'h0, 8'hFF);
    @(negedge clk);
    // R9: idle cycle
    chk("R9", "idle valid", {31'b0, out_valid}, 32'd0);
    chk("R9", "idle target", {30'b0, out_target}, 32'd0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++)
      access($urandom, 1'($urandom), $urandom, 8'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule